// File: doc/BRIEF.md
# Ramp Missing-Code Checker

This block is the digital side of a missing-code scan on an analog-to-digital converter whose input is swept by a slow, monotonic ramp. The host gives a starting code, usually zero, and a timeout length in clock cycles. It then pulses a start strobe. From that point the checker holds an expected-code counter and compares it with every conversion result the converter reports.

A conversion that equals the expected code moves the counter up by one. Since the ramp crosses each code over several conversions, the counter advances once per code and then waits for the next code. An idle timer counts clock cycles in which no advance happens, but only while the scan-enable input is high. It restarts on every advance. If the timer reaches the programmed window, the scan fails and the stalled counter value is reported as the missing code.

The scan passes once the counter holds the converter's full-scale (all-ones) code. After a pass or a fail the checker freezes until the next start. The counter value is visible on an output at all times, so the host can follow the scan's progress.

Top module: `ramp_code_checker`

## Requirements
- R1: After reset, busy, pass and fail are low, and both the expected code and the failing code are zero.
- R2: A start strobe, sampled at a clock edge, loads the preset code into the expected code, sets busy, and clears pass and fail from that edge on.
- R3: While busy, a valid conversion whose code equals the expected code raises the expected code by exactly one at the next edge. A non-matching or invalid conversion leaves it unchanged.
- R4: Holding a matching code valid for several consecutive cycles advances the counter only once. The repeated old code no longer equals the new expected code.
- R5: While busy with scan-enable high, the scan fails when max(window,1) consecutive cycles pass without an advance. At the same edge busy drops, fail rises and the failing code takes the stalled expected code.
- R6: Every advance restarts the idle count from zero, so a scan that advances at least once per window never fails.
- R7: While scan-enable is low, the idle count holds its value. A stall of any length with scan-enable low does not cause a fail.
- R8: One edge after the expected code holds all ones while busy, busy drops and pass rises. A preset of all ones therefore passes one cycle after start.
- R9: After pass or fail, conversions and scan-enable have no effect: the expected code, the failing code and the flags stay constant until the next start.
- R10: A start strobe during a running scan restarts the scan from the new preset, with a fresh idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset, asynchronous |
| startScan | input | 1 | One-cycle strobe that begins (or restarts) a scan |
| presetCode | input | CODE_W | Starting expected code loaded on start |
| windowCycles | input | TMR_W | Idle cycles allowed between advances (0 acts as 1) |
| scanEnable | input | 1 | Lets the idle timer run while high |
| convValid | input | 1 | A conversion result is present this cycle |
| convCode | input | CODE_W | Conversion result from the converter under test |
| expCode | output | CODE_W | Current expected-code counter |
| busy | output | 1 | Scan in progress |
| pass | output | 1 | Counter reached full scale with no timeout |
| fail | output | 1 | Timeout occurred; a code is missing |
| failCode | output | CODE_W | Expected code at the time of the timeout |

## Verification
The bench builds the checker with a 4-bit code width and a 6-bit window counter. At that size a complete scan from zero to full scale takes under a hundred cycles. Many whole ramps therefore fit into the run: clean ones, ramps with a skipped code placed anywhere, and noisy ramps whose reading lags by a code. The small window field also puts the zero-window, one-cycle-window and paused-timer corners within easy reach.

// File: rtl/rampchk_pkg.sv
package rampchk_pkg;

  typedef struct packed {
    logic load;     // take the preset, clear the idle count
    logic advance;  // expected code + 1, clear the idle count
    logic tick;     // one more idle cycle
    logic capture;  // latch the failing code
  } dpCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_PASS = 2'd2,
    ST_FAIL = 2'd3
  } scanState_t;

endpackage

// File: rtl/rampchk_datapath.sv
module rampchk_datapath
  import rampchk_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [CODE_W-1:0] presetCode,
  input  logic [TMR_W-1:0]  windowCycles,
  input  logic              convValid,
  input  logic [CODE_W-1:0] convCode,
  output logic [CODE_W-1:0] expCode,
  output logic [CODE_W-1:0] failCode,
  output logic              matchHit,
  output logic              atTop,
  output logic              timeUp
);

  localparam logic [CODE_W-1:0] TOP_CODE = {CODE_W{1'b1}};

  logic [TMR_W-1:0] idleCnt;
  logic [TMR_W:0]   idleNext;

  // expected-code counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expCode <= '0;
    end else if (ctl.load) begin
      expCode <= presetCode;
    end else if (ctl.advance) begin
      expCode <= expCode + 1'b1;
    end
  end

  // idle timer: counts enabled cycles without an advance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (ctl.load || ctl.advance) begin
      idleCnt <= '0;
    end else if (ctl.tick) begin
      idleCnt <= idleNext[TMR_W-1:0];
    end
  end

  // failing-code capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCode <= '0;
    end else if (ctl.capture) begin
      failCode <= expCode;
    end
  end

  always_comb begin
    idleNext = {1'b0, idleCnt} + 1'b1;
    // a zero window behaves as a one-cycle window
    timeUp   = idleNext >= {1'b0, windowCycles};
    matchHit = convValid && (convCode == expCode);
    atTop    = (expCode == TOP_CODE);
  end

endmodule

// File: rtl/rampchk_control.sv
module rampchk_control
  import rampchk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startScan,
  input  logic    scanEnable,
  input  logic    matchHit,
  input  logic    atTop,
  input  logic    timeUp,
  output dpCtrl_t ctl,
  output logic    busy,
  output logic    pass,
  output logic    fail
);

  scanState_t state, stateNext;
  logic       running;

  always_comb begin
    running     = (state == ST_SCAN) && !startScan;
    ctl.load    = startScan;
    // full scale is final: no advance past it
    ctl.advance = running && !atTop && matchHit;
    ctl.tick    = running && !atTop && !matchHit && scanEnable;
    ctl.capture = ctl.tick && timeUp;

    stateNext = state;
    if (startScan) begin
      stateNext = ST_SCAN;
    end else if (state == ST_SCAN) begin
      if (atTop) begin
        stateNext = ST_PASS;
      end else if (ctl.capture) begin
        stateNext = ST_FAIL;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign busy = (state == ST_SCAN);
  assign pass = (state == ST_PASS);
  assign fail = (state == ST_FAIL);

endmodule

// File: rtl/ramp_code_checker.sv
module ramp_code_checker
  import rampchk_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startScan,
  input  logic [CODE_W-1:0] presetCode,
  input  logic [TMR_W-1:0]  windowCycles,
  input  logic              scanEnable,
  input  logic              convValid,
  input  logic [CODE_W-1:0] convCode,
  output logic [CODE_W-1:0] expCode,
  output logic              busy,
  output logic              pass,
  output logic              fail,
  output logic [CODE_W-1:0] failCode
);

  dpCtrl_t ctl;
  logic    matchHit;
  logic    atTop;
  logic    timeUp;

  rampchk_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startScan (startScan),
    .scanEnable(scanEnable),
    .matchHit  (matchHit),
    .atTop     (atTop),
    .timeUp    (timeUp),
    .ctl       (ctl),
    .busy      (busy),
    .pass      (pass),
    .fail      (fail)
  );

  rampchk_datapath #(
    .CODE_W(CODE_W),
    .TMR_W (TMR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .presetCode  (presetCode),
    .windowCycles(windowCycles),
    .convValid   (convValid),
    .convCode    (convCode),
    .expCode     (expCode),
    .failCode    (failCode),
    .matchHit    (matchHit),
    .atTop       (atTop),
    .timeUp      (timeUp)
  );

endmodule

// File: rtl/rampchk_props.sv
module rampchk_props #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              startScan,
  input logic [CODE_W-1:0] presetCode,
  input logic              convValid,
  input logic [CODE_W-1:0] convCode,
  input logic [CODE_W-1:0] expCode,
  input logic              busy,
  input logic              pass,
  input logic              fail,
  input logic [CODE_W-1:0] failCode
);

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    startScan |=> busy && !pass && !fail && (expCode == $past(presetCode)));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !startScan && convValid && (convCode == expCode) && !(&expCode)
      |=> expCode == $past(expCode) + 1'b1);

  p_hold_mismatch_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !startScan && !(convValid && (convCode == expCode)) |=> $stable(expCode));

  p_fail_code_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fail) |-> failCode == expCode);

  p_pass_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> &expCode);

  p_flags_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, pass, fail}));

  p_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pass || fail) && !startScan |=> $stable(expCode) && $stable(failCode)
      && $stable(pass) && $stable(fail));

endmodule

bind ramp_code_checker rampchk_props #(.CODE_W(CODE_W)) u_props (
  .clk       (clk),
  .rstN      (rstN),
  .startScan (startScan),
  .presetCode(presetCode),
  .convValid (convValid),
  .convCode  (convCode),
  .expCode   (expCode),
  .busy      (busy),
  .pass      (pass),
  .fail      (fail),
  .failCode  (failCode)
);

// File: tb/sim_ramp_code_checker.sv
module sim_ramp_code_checker;

  localparam int CODE_W = 4;
  localparam int TMR_W  = 6;
  localparam int TOP    = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startScan = 1'b0;
  logic [CODE_W-1:0] presetCode = '0;
  logic [TMR_W-1:0]  windowCycles = '0;
  logic              scanEnable = 1'b0;
  logic              convValid = 1'b0;
  logic [CODE_W-1:0] convCode = '0;
  logic [CODE_W-1:0] expCode;
  logic              busy, pass, fail;
  logic [CODE_W-1:0] failCode;

  always #5 clk = ~clk;

  ramp_code_checker #(.CODE_W(CODE_W), .TMR_W(TMR_W)) u0 (
    .clk(clk), .rstN(rstN), .startScan(startScan), .presetCode(presetCode),
    .windowCycles(windowCycles), .scanEnable(scanEnable), .convValid(convValid),
    .convCode(convCode), .expCode(expCode), .busy(busy), .pass(pass),
    .fail(fail), .failCode(failCode)
  );

  int    nChecks = 0;
  int    nFails  = 0;
  int    cycles  = 0;
  string curTag  = "R1";

  // reference model, state: 0 idle, 1 scan, 2 pass, 3 fail
  int mExp = 0, mState = 0, mTimer = 0, mFailCode = 0;

  task automatic check(input string tag, input bit ok, input string act, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  function automatic string fmt(int e, int s, int fc);
    return $sformatf("exp=%0d state=%0d failCode=%0d", e, s, fc);
  endfunction

  function automatic int dutState();
    return busy ? 1 : pass ? 2 : fail ? 3 : 0;
  endfunction

  // next model state from the current inputs, applied at the coming edge
  task automatic modelEdge();
    int w;
    w = (windowCycles == 0) ? 1 : int'(windowCycles);
    if (!rstN) begin
      mExp = 0; mState = 0; mTimer = 0; mFailCode = 0;
    end else if (startScan) begin
      mExp = int'(presetCode); mState = 1; mTimer = 0;
    end else if (mState == 1) begin
      if (mExp == TOP) mState = 2;
      else if (convValid && int'(convCode) == mExp) begin
        mExp++; mTimer = 0;
      end else if (scanEnable) begin
        if (mTimer + 1 >= w) begin mState = 3; mFailCode = mExp; end
        else mTimer++;
      end
    end
  endtask

  task automatic cycle();
    modelEdge();
    @(negedge clk);
    check(curTag, int'(expCode) == mExp && dutState() == mState
          && int'(failCode) == mFailCode,
          fmt(int'(expCode), dutState(), int'(failCode)),
          fmt(mExp, mState, mFailCode));
  endtask

  task automatic idleInputs();
    startScan = 0; convValid = 0; convCode = '0;
  endtask

  task automatic start(input int preset, input int window, input bit en);
    presetCode = CODE_W'(preset); windowCycles = TMR_W'(window);
    scanEnable = en; convValid = 0; startScan = 1;
    cycle();
    startScan = 0;
  endtask

  // ramp stimulus: perCode conversions per code, optional skipped code,
  // optional lag-by-one noise, random valid gaps
  task automatic ramp(input int preset, input int perCode, input int skip,
                      input bit noisy, input int validPct);
    int k = 0;
    for (int c = 0; c < 600 && mState == 1; c++) begin
      int code;
      if ($urandom_range(99) < validPct) begin
        code = preset + k / perCode;
        if (code > TOP) code = TOP;
        if (noisy && code > 0 && $urandom_range(3) == 0) code--;
        if (code == skip) code = (skip < TOP) ? skip + 1 : skip - 1;
        convValid = 1; convCode = CODE_W'(code); k++;
      end else begin
        convValid = 0;
      end
      cycle();
    end
    idleInputs();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    nFails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    curTag = "R1";
    rstN = 0;
    cycle(); cycle();
    rstN = 1;
    cycle();
    check("R1", !busy && !pass && !fail && expCode == 0 && failCode == 0,
          fmt(int'(expCode), dutState(), int'(failCode)), fmt(0, 0, 0));

    // R3 R8: clean full ramp from zero
    curTag = "R3";
    start(0, 40, 1);
    check("R2", busy && expCode == 0, fmt(int'(expCode), dutState(), 0), fmt(0, 1, 0));
    ramp(0, 3, -1, 0, 100);
    cycle();
    check("R8", pass && !busy && expCode == TOP,
          fmt(int'(expCode), dutState(), int'(failCode)), fmt(TOP, 2, 0));

    // R9: conversions after pass ignored
    curTag = "R9";
    scanEnable = 1;
    for (int i = 0; i < 6; i++) begin
      convValid = 1; convCode = CODE_W'(i); cycle();
    end
    idleInputs();
    check("R9", pass && expCode == TOP, fmt(int'(expCode), dutState(), 0), fmt(TOP, 2, 0));

    // R5: skipped code 9 stalls the counter
    curTag = "R5";
    start(0, 20, 1);
    ramp(0, 3, 9, 0, 100);
    check("R5", fail && !busy && failCode == 9 && expCode == 9,
          fmt(int'(expCode), dutState(), int'(failCode)), fmt(9, 3, 9));

    // R9: matching the failed code afterwards does nothing
    curTag = "R9";
    for (int i = 0; i < 5; i++) begin
      convValid = 1; convCode = 4'd9; scanEnable = 1; cycle();
    end
    idleInputs();
    check("R9", fail && expCode == 9 && failCode == 9,
          fmt(int'(expCode), dutState(), int'(failCode)), fmt(9, 3, 9));

    // R8: preset at full scale passes one cycle after start
    curTag = "R8";
    start(TOP, 10, 1);
    check("R8", busy, fmt(int'(expCode), dutState(), 0), fmt(TOP, 1, 0));
    cycle();
    check("R8", pass && !busy, fmt(int'(expCode), dutState(), 0), fmt(TOP, 2, 0));

    // R5: zero window acts as one cycle
    curTag = "R5";
    start(4, 0, 1);
    cycle();
    check("R5", fail && failCode == 4, fmt(int'(expCode), dutState(), int'(failCode)),
          fmt(4, 3, 4));
    start(6, 1, 1);
    cycle();
    check("R5", fail && failCode == 6, fmt(int'(expCode), dutState(), int'(failCode)),
          fmt(6, 3, 6));

    // R7: paused timer with enable low
    curTag = "R7";
    start(3, 5, 0);
    for (int i = 0; i < 30; i++) cycle();
    check("R7", busy && expCode == 3, fmt(int'(expCode), dutState(), 0), fmt(3, 1, 0));
    scanEnable = 1;
    for (int i = 0; i < 4; i++) cycle();
    check("R7", busy, fmt(int'(expCode), dutState(), 0), fmt(3, 1, 0));
    cycle();
    check("R5", fail && failCode == 3, fmt(int'(expCode), dutState(), int'(failCode)),
          fmt(3, 3, 3));

    // R6: advance every 4 cycles with a 5-cycle window
    curTag = "R6";
    start(1, 5, 1);
    for (int c = 1; c < 8; c++) begin
      for (int j = 0; j < 3; j++) cycle();
      convValid = 1; convCode = CODE_W'(c); cycle(); convValid = 0;
    end
    check("R6", busy && expCode == 8, fmt(int'(expCode), dutState(), 0), fmt(8, 1, 0));

    // R4: a held matching code advances once
    curTag = "R4";
    start(2, 30, 1);
    convValid = 1; convCode = 4'd2;
    for (int i = 0; i < 6; i++) cycle();
    idleInputs();
    check("R4", busy && expCode == 3, fmt(int'(expCode), dutState(), 0), fmt(3, 1, 0));

    // R10: restart while busy
    curTag = "R10";
    start(11, 30, 1);
    check("R10", busy && expCode == 11, fmt(int'(expCode), dutState(), 0), fmt(11, 1, 0));
    ramp(11, 2, -1, 0, 100);
    check("R10", pass, fmt(int'(expCode), dutState(), 0), fmt(TOP, 2, 0));

    // R3 R5 R6: randomized noisy ramps, checked cycle by cycle
    curTag = "R3";
    for (int s = 0; s < 60; s++) begin
      int pre = $urandom_range(TOP);
      int skip = ($urandom_range(2) == 0) ? int'($urandom_range(TOP)) : -1;
      start(pre, 8 + $urandom_range(40), $urandom_range(7) != 0);
      ramp(pre, 2 + $urandom_range(3), skip, $urandom_range(1) == 1,
           50 + $urandom_range(50));
      for (int i = 0; i < 3; i++) cycle();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule